// File: doc/BRIEF.md
# Priority Peripheral-to-Pin Crossbar

This block decides which internal peripheral signal appears on each pin of a bank of general-purpose pins. The bank is built from 8-bit ports, three by default, giving 24 pins. Software writes three 8-bit configuration registers that switch peripheral signal groups on or off and set a global enable. The block then hands out pins in one fixed priority order. The first enabled signal gets pin 0, and each later enabled signal takes the next free pin. Signals that belong to one peripheral therefore sit on adjacent pins. Every pin left over behaves as an open-drain general-purpose pin driven from its port latch bit.

For each pin the block produces an output value, an output enable and an owner code. Each peripheral receives the level of the pin it owns. There are 24 routable signals. When the bank has fewer pins than there are enabled signals, the lowest-priority signals get no pin and an overflow flag is set. Pin ownership is exclusive. The peripheral alone drives a pin it owns, even while that peripheral is idle.

The pin map is decoded combinationally from the configuration registers. All pin-side results are registered. The only exception is the inverted-clock signal, which passes through as a live clock.

Top module: `pin_priority_xbar`

## Requirements
- R1: A synchronous reset clears the three configuration registers. After reset, every pin output enable is 0, every owner code is 0, `overflow_o` is 0 and every `sig_in_o` bit is 1.
- R2: Bit 6 of configuration register C is the global enable. While it is 0, no pin is assigned, every `pin_oe_o` bit is 0, every owner code is 0, every `sig_in_o` bit is 1, and `pin_out_o` follows the port latch.
- R3: Signal indices in priority order (0 is highest) are: 0 SDA, 1 SCL, 2 SCK, 3 MISO, 4 MOSI, 5 NSS, 6 TX, 7 RX, 8..12 CEX0..CEX4, 13 ECI, 14 CP0, 15 CP1, 16 T0, 17 INT0, 18 T1, 19 INT1, 20 T2, 21 T2EX, 22 inverted clock, 23 CNVSTR. An enabled signal is placed on the pin whose index equals the number of enabled signals with a lower index.
- R4: Register A enables groups as follows. Bit 0 enables signals 0-1, bit 1 enables signals 2..5, and bit 2 enables signals 6-7. Bits 5:3 hold a count n: signals 8 .. 8+min(n,5)-1 are enabled, starting from CEX0. Bit 6 enables signal 13. In register B, bit i enables signal 14+i for i from 0 to 7. In register C, bit 1 enables signal 22 and bit 0 enables signal 23.
- R5: The owner code of each pin is 5 bits wide, at bits [5p+4:5p] of `pin_owner_o`. It is 0 for a general-purpose pin and s+1 for a pin that carries signal s.
- R6: A pin that carries signal s drives `sig_out_i[s]`. Its enable is `sig_oe_i[s]` for the output-capable signals 0..6, 8..12, 14, 15 and 22, and 0 for all other signals. The port latch has no effect on that pin.
- R7: When the global enable is set, an unassigned pin drives its latch bit as open drain: the output value equals the latch bit and the enable equals the inverse of the latch bit.
- R8: `sig_in_o[s]` equals `pin_in_i` of the pin assigned to signal s. If signal s has no pin, it is 1.
- R9: The pin carrying signal 22 outputs the inverted clock, and its enable is always 1.
- R10: When more signals are enabled than there are pins, `overflow_o` is 1 and the signals beyond the last pin get no pin. Otherwise `overflow_o` is 0.
- R11: A configuration write is captured on a clock edge; strobe bit k selects register A, B or C for k = 0, 1, 2. Pin results appear on the following edge. A change of `sig_out_i`, `sig_oe_i`, the latch or `pin_in_i` appears after exactly one edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| cfg_we_i | input | 3 | Write strobes for configuration registers A, B, C |
| cfg_wdata_i | input | 8 | Configuration write data |
| sig_out_i | input | 24 | Output value of each peripheral signal |
| sig_oe_i | input | 24 | Output enable of each peripheral signal |
| port_latch_i | input | NPINS | Port latch bit per pin |
| pin_in_i | input | NPINS | Level sensed at each pin |
| pin_out_o | output | NPINS | Value driven on each pin |
| pin_oe_o | output | NPINS | Output enable of each pin |
| pin_owner_o | output | NPINS*5 | Owner code per pin |
| sig_in_o | output | 24 | Pin level returned to each peripheral signal |
| overflow_o | output | 1 | More signals enabled than pins available |

## Verification
The bench checks a 24-pin and a 16-pin instance side by side with random register values. The 16-pin instance shows truncation and overflow that the full bank never reaches. Directed patterns cover the following cases:
- A single four-signal group, which shows where packing starts.
- A CEX count of 7, which shows the clamp to five.
- Every group enabled, which fills the last pin exactly on one instance and overflows the other.
- The global enable cleared while latches are low, which separates the disable behaviour from open-drain GPIO drive.
- A peripheral that owns a pin with its enable low while the latch is low, which shows that the latch is locked out.
- A clock-phase probe of the inverted clock pin.
- Single-edge stepping after a write and after a data change, which pins down the two latencies.

// File: rtl/xbar_pkg.sv
package xbar_pkg;
  localparam int NSIG     = 24;
  localparam int OWN_W    = 5;
  localparam int CFG_W    = 8;
  localparam int GLB_BIT  = 6;
  localparam int CEX_BASE = 8;
  localparam int CEX_MAX  = 5;
  localparam int SIG_ECI  = 13;
  localparam int MISC_BASE = 14;
  localparam int MISC_CNT = 8;
  localparam int SIG_NCLK = 22;
  localparam int SIG_CNV  = 23;
  typedef logic [NSIG-1:0] sig_vec_t;
  // signals that may actually drive a pin
  localparam sig_vec_t OUT_CAPABLE = 24'h40DF7F;
endpackage

// File: rtl/xbar_enable_decode.sv
module xbar_enable_decode
  import xbar_pkg::*;
(
  input  logic [CFG_W-1:0] cfg_a_i,
  input  logic [CFG_W-1:0] cfg_b_i,
  input  logic [CFG_W-1:0] cfg_c_i,
  output sig_vec_t         en_o
);
  logic [2:0] cex_n;
  sig_vec_t   raw;

  assign cex_n = cfg_a_i[5:3];

  always_comb begin
    raw = '0;
    raw[0] = cfg_a_i[0];
    raw[1] = cfg_a_i[0];
    for (int i = 2; i < 6; i++) raw[i] = cfg_a_i[1];
    raw[6] = cfg_a_i[2];
    raw[7] = cfg_a_i[2];
    for (int i = 0; i < CEX_MAX; i++) raw[CEX_BASE+i] = (cex_n > 3'(i));
    raw[SIG_ECI] = cfg_a_i[6];
    for (int i = 0; i < MISC_CNT; i++) raw[MISC_BASE+i] = cfg_b_i[i];
    raw[SIG_NCLK] = cfg_c_i[1];
    raw[SIG_CNV]  = cfg_c_i[0];
  end

  assign en_o = cfg_c_i[GLB_BIT] ? raw : '0;
endmodule

// File: rtl/xbar_slot_alloc.sv
module xbar_slot_alloc
  import xbar_pkg::*;
#(
  parameter int NPINS  = 24,
  parameter int SLOT_W = 5
) (
  input  sig_vec_t                     en_i,
  output logic [NSIG-1:0][SLOT_W-1:0]  slot_o,
  output sig_vec_t                     placed_o,
  output logic                         overflow_o
);
  int run;

  always_comb begin
    run = 0;
    slot_o = '0;
    placed_o = '0;
    for (int s = 0; s < NSIG; s++) begin
      slot_o[s]   = SLOT_W'(run);
      placed_o[s] = en_i[s] && (run < NPINS);
      if (en_i[s]) run++;
    end
    overflow_o = (run > NPINS);
  end
endmodule

// File: rtl/xbar_pin_route.sv
module xbar_pin_route
  import xbar_pkg::*;
#(
  parameter int NPINS  = 24,
  parameter int SLOT_W = 5
) (
  input  logic                         glb_i,
  input  logic [NSIG-1:0][SLOT_W-1:0]  slot_i,
  input  sig_vec_t                     placed_i,
  input  sig_vec_t                     sig_out_i,
  input  sig_vec_t                     sig_oe_i,
  input  logic [NPINS-1:0]             latch_i,
  input  logic [NPINS-1:0]             pin_in_i,
  output logic [NPINS-1:0]             out_o,
  output logic [NPINS-1:0]             oe_o,
  output logic [NPINS-1:0][OWN_W-1:0]  own_o,
  output logic [NPINS-1:0]             nclk_o,
  output sig_vec_t                     sig_in_o
);
  always_comb begin
    for (int p = 0; p < NPINS; p++) begin
      own_o[p]  = '0;
      out_o[p]  = latch_i[p];
      oe_o[p]   = glb_i & ~latch_i[p];
      nclk_o[p] = 1'b0;
      for (int s = 0; s < NSIG; s++) begin
        if (placed_i[s] && slot_i[s] == SLOT_W'(p)) begin
          own_o[p] = OWN_W'(s + 1);
          out_o[p] = sig_out_i[s];
          oe_o[p]  = (s == SIG_NCLK) ? 1'b1 : (sig_oe_i[s] & OUT_CAPABLE[s]);
          nclk_o[p] = (s == SIG_NCLK);
        end
      end
    end
  end

  always_comb begin
    for (int s = 0; s < NSIG; s++)
      sig_in_o[s] = placed_i[s] ? pin_in_i[slot_i[s]] : 1'b1;
  end
endmodule

// File: rtl/pin_priority_xbar.sv
module pin_priority_xbar
  import xbar_pkg::*;
#(
  parameter int NUM_PORTS = 3,
  parameter int PORT_W    = 8
) (
  input  logic                         clk_i,
  input  logic                         rst_i,
  input  logic [2:0]                   cfg_we_i,
  input  logic [CFG_W-1:0]             cfg_wdata_i,
  input  logic [NSIG-1:0]              sig_out_i,
  input  logic [NSIG-1:0]              sig_oe_i,
  input  logic [NUM_PORTS*PORT_W-1:0]  port_latch_i,
  input  logic [NUM_PORTS*PORT_W-1:0]  pin_in_i,
  output logic [NUM_PORTS*PORT_W-1:0]  pin_out_o,
  output logic [NUM_PORTS*PORT_W-1:0]  pin_oe_o,
  output logic [NUM_PORTS*PORT_W*OWN_W-1:0] pin_owner_o,
  output logic [NSIG-1:0]              sig_in_o,
  output logic                         overflow_o
);
  localparam int NPINS  = NUM_PORTS * PORT_W;
  localparam int SLOT_W = $clog2((NPINS > NSIG ? NPINS : NSIG) + 1);

  logic [CFG_W-1:0] cfg_a_q, cfg_b_q, cfg_c_q;
  sig_vec_t en_c, placed_c, sin_c, sin_q;
  logic [NSIG-1:0][SLOT_W-1:0] slot_c;
  logic ovf_c, ovf_q;
  logic [NPINS-1:0] out_c, oe_c, nclk_c, out_q, oe_q, nclk_q;
  logic [NPINS-1:0][OWN_W-1:0] own_c, own_q;

  xbar_enable_decode u_dec (
    .cfg_a_i(cfg_a_q), .cfg_b_i(cfg_b_q), .cfg_c_i(cfg_c_q), .en_o(en_c)
  );

  xbar_slot_alloc #(.NPINS(NPINS), .SLOT_W(SLOT_W)) u_alloc (
    .en_i(en_c), .slot_o(slot_c), .placed_o(placed_c), .overflow_o(ovf_c)
  );

  xbar_pin_route #(.NPINS(NPINS), .SLOT_W(SLOT_W)) u_route (
    .glb_i(cfg_c_q[GLB_BIT]), .slot_i(slot_c), .placed_i(placed_c),
    .sig_out_i(sig_out_i), .sig_oe_i(sig_oe_i), .latch_i(port_latch_i),
    .pin_in_i(pin_in_i), .out_o(out_c), .oe_o(oe_c), .own_o(own_c),
    .nclk_o(nclk_c), .sig_in_o(sin_c)
  );

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      cfg_a_q <= '0;
      cfg_b_q <= '0;
      cfg_c_q <= '0;
      out_q   <= '0;
      oe_q    <= '0;
      own_q   <= '0;
      nclk_q  <= '0;
      sin_q   <= '1;
      ovf_q   <= 1'b0;
    end else begin
      if (cfg_we_i[0]) cfg_a_q <= cfg_wdata_i;
      if (cfg_we_i[1]) cfg_b_q <= cfg_wdata_i;
      if (cfg_we_i[2]) cfg_c_q <= cfg_wdata_i;
      out_q  <= out_c;
      oe_q   <= oe_c;
      own_q  <= own_c;
      nclk_q <= nclk_c;
      sin_q  <= sin_c;
      ovf_q  <= ovf_c;
    end
  end

  assign pin_out_o   = (out_q & ~nclk_q) | (nclk_q & {NPINS{~clk_i}});
  assign pin_oe_o    = oe_q;
  assign pin_owner_o = own_q;
  assign sig_in_o    = sin_q;
  assign overflow_o  = ovf_q;

  // R2: with the global enable clear, nothing drives a pin one edge later
  assert_off_no_drive_R2: assert property (@(posedge clk_i) disable iff (rst_i)
    !cfg_c_q[GLB_BIT] |=> (oe_q == '0));

  // R10: an overflow means the last pin was taken by a peripheral
  assert_overflow_full_R10: assert property (@(posedge clk_i) disable iff (rst_i)
    ovf_c |=> (own_q[NPINS-1] != '0));

  for (genvar p = 0; p < NPINS; p++) begin : g_pin_chk
    // R7: general-purpose pins follow the latch sampled on the previous edge
    assert_gpio_latch_R7: assert property (@(posedge clk_i) disable iff (rst_i)
      (own_c[p] == '0) |=> (out_q[p] == $past(port_latch_i[p])));
    // R9: the inverted clock pin is always driven
    assert_nclk_drive_R9: assert property (@(posedge clk_i) disable iff (rst_i)
      nclk_q[p] |-> oe_q[p]);
  end
endmodule

// File: tb/pin_priority_xbar_tb_top.sv
module pin_priority_xbar_tb_top;
  logic clk = 1'b0;
  logic rst;
  logic [2:0] cfg_we;
  logic [7:0] cfg_wdata;
  logic [23:0] sig_out, sig_oe, latch, pin_in;
  logic [23:0] b_out, b_oe, b_sin;
  logic [119:0] b_own;
  logic b_ovf;
  logic [15:0] s_out, s_oe;
  logic [23:0] s_sin;
  logic [79:0] s_own;
  logic s_ovf;
  logic [7:0] m_a, m_b, m_c;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  pin_priority_xbar dut_i (
    .clk_i(clk), .rst_i(rst), .cfg_we_i(cfg_we), .cfg_wdata_i(cfg_wdata),
    .sig_out_i(sig_out), .sig_oe_i(sig_oe), .port_latch_i(latch), .pin_in_i(pin_in),
    .pin_out_o(b_out), .pin_oe_o(b_oe), .pin_owner_o(b_own), .sig_in_o(b_sin),
    .overflow_o(b_ovf)
  );

  pin_priority_xbar #(.NUM_PORTS(2)) dut_s_i (
    .clk_i(clk), .rst_i(rst), .cfg_we_i(cfg_we), .cfg_wdata_i(cfg_wdata),
    .sig_out_i(sig_out), .sig_oe_i(sig_oe), .port_latch_i(latch[15:0]),
    .pin_in_i(pin_in[15:0]), .pin_out_o(s_out), .pin_oe_o(s_oe),
    .pin_owner_o(s_own), .sig_in_o(s_sin), .overflow_o(s_ovf)
  );

  task automatic chk(input bit ok, input string what, input logic [127:0] act,
                     input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", what, act, exp);
    end
  endtask

  // R4: enable vector from the register layout
  function automatic logic [23:0] model_en();
    logic [23:0] e = '0;
    if (!m_c[6]) return '0;
    e[1:0] = {2{m_a[0]}};
    e[5:2] = {4{m_a[1]}};
    e[7:6] = {2{m_a[2]}};
    for (int i = 0; i < 5; i++) e[8+i] = (int'(m_a[5:3]) > i);
    e[13] = m_a[6];
    e[21:14] = m_b;
    e[22] = m_c[1];
    e[23] = m_c[0];
    return e;
  endfunction

  function automatic logic [23:0] out_capable();
    logic [23:0] c = '0;
    for (int i = 0; i <= 6; i++) c[i] = 1'b1;
    for (int i = 8; i <= 12; i++) c[i] = 1'b1;
    c[14] = 1'b1; c[15] = 1'b1; c[22] = 1'b1;
    return c;
  endfunction

  task automatic cmp_dut(input string tag, input int np, input logic [23:0] out,
                         input logic [23:0] oe, input logic [23:0] sin,
                         input logic [119:0] own, input logic ovf, input bit clk_hi);
    logic [23:0] en = model_en();
    logic [23:0] cap = out_capable();
    logic [23:0] e_out, e_oe, e_sin, pm;
    logic [119:0] e_own = '0, om = '0;
    int k = 0;
    e_sin = '1;
    e_out = latch;
    e_oe = {24{m_c[6]}} & ~latch;
    pm = '0;
    for (int p = 0; p < np; p++) begin
      pm[p] = 1'b1;
      om[p*5 +: 5] = 5'h1f;
    end
    for (int s = 0; s < 24; s++) begin
      if (en[s]) begin
        if (k < np) begin
          e_own[k*5 +: 5] = 5'(s + 1);
          e_out[k] = (s == 22) ? ~clk_hi : sig_out[s];
          e_oe[k]  = (s == 22) ? 1'b1 : (sig_oe[s] & cap[s]);
          e_sin[s] = pin_in[k];
        end
        k++;
      end
    end
    chk((own & om) == (e_own & om), {tag, " R3 R4 R5 owner"}, 128'(own & om), 128'(e_own & om));
    chk((out & pm) == (e_out & pm), {tag, " R6 R7 R9 pin_out"}, 128'(out & pm), 128'(e_out & pm));
    chk((oe & pm) == (e_oe & pm), {tag, " R2 R6 R7 pin_oe"}, 128'(oe & pm), 128'(e_oe & pm));
    chk(sin == e_sin, {tag, " R8 sig_in"}, 128'(sin), 128'(e_sin));
    chk(ovf == (k > np), {tag, " R10 overflow"}, 128'(ovf), 128'(k > np));
  endtask

  task automatic cmp_both(input string tag, input bit clk_hi);
    cmp_dut({tag, " big"}, 24, b_out, b_oe, b_sin, b_own, b_ovf, clk_hi);
    cmp_dut({tag, " small"}, 16, {8'h0, s_out}, {8'h0, s_oe}, s_sin, {40'h0, s_own}, s_ovf, clk_hi);
  endtask

  task automatic wr(input int k, input logic [7:0] v);
    @(negedge clk);
    cfg_we = 3'(1 << k);
    cfg_wdata = v;
    if (k == 0) m_a = v; else if (k == 1) m_b = v; else m_c = v;
    @(negedge clk);
    cfg_we = '0;
  endtask

  task automatic settle();
    @(negedge clk);
    #1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog expired R11 act=hung exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed));
    rst = 1'b1; cfg_we = '0; cfg_wdata = '0;
    sig_out = '0; sig_oe = '0; latch = '0; pin_in = '0;
    m_a = '0; m_b = '0; m_c = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    settle();
    // R1: state after reset
    chk(b_oe == '0, "R1 reset oe", 128'(b_oe), 0);
    chk(b_own == '0, "R1 reset owner", 128'(b_own), 0);
    chk(b_sin == '1 && !b_ovf, "R1 reset sig_in/overflow", 128'({b_ovf, b_sin}), 128'(24'hffffff));

    // R3 R4: single four-signal group packs from pin 0
    sig_out = 24'h00003c; sig_oe = '1; latch = 24'h0f0f0f;
    wr(0, 8'h02); wr(2, 8'h40); settle();
    chk(b_own[19:0] == {5'd6, 5'd5, 5'd4, 5'd3} && b_own[24:20] == 0,
        "R3 group on pins 0..3", 128'(b_own[24:0]), 128'({5'd0, 5'd6, 5'd5, 5'd4, 5'd3}));
    cmp_both("spi", 1'b0);

    // R6: owner with enable low keeps the pin released despite a low latch
    wr(0, 8'h01); sig_oe = 24'h0; latch = 24'h0; settle();
    chk(b_oe[1:0] == 2'b00 && b_oe[2] == 1'b1, "R6 latch locked out", 128'(b_oe[2:0]), 128'(3'b100));

    // R2: global enable cleared, latches low
    wr(2, 8'h00); settle();
    chk(b_oe == '0 && b_own == '0, "R2 disabled no drive", 128'(b_oe), 0);
    chk(b_out == latch, "R2 out follows latch", 128'(b_out), 128'(latch));
    cmp_both("off", 1'b0);

    // R4: CEX count 7 clamps to five
    wr(0, 8'h38); wr(2, 8'h40); settle();
    chk(b_own[24:20] == 5'd13 && b_own[29:25] == 5'd0, "R4 CEX clamp", 128'(b_own[29:20]), 128'({5'd0, 5'd13}));

    // R9: inverted clock pin
    wr(0, 8'h00); wr(2, 8'h42); settle();
    chk(b_own[4:0] == 5'd23 && b_out[0] == 1'b1 && b_oe[0], "R9 clock low phase", 128'({b_oe[0], b_out[0]}), 128'(2'b11));
    @(posedge clk); #1;
    chk(b_out[0] == 1'b0, "R9 clock high phase", 128'(b_out[0]), 0);

    // R10: every group enabled
    sig_oe = '1; pin_in = 24'ha5c3e1;
    wr(0, 8'h7f); wr(1, 8'hff); wr(2, 8'h43); settle();
    chk(b_own[119:115] == 5'd24 && !b_ovf, "R10 full bank exact", 128'({b_ovf, b_own[119:115]}), 128'(24));
    chk(s_ovf && s_sin[23] == 1'b1 && s_own[79:75] == 5'd16, "R10 small overflow", 128'({s_ovf, s_own[79:75]}), 128'({1'b1, 5'd16}));
    cmp_both("full", 1'b0);

    // R11: write latency and data latency
    @(negedge clk);
    cfg_we = 3'b001; cfg_wdata = 8'h00; m_a = 8'h00;
    @(negedge clk); cfg_we = '0; #1;
    chk(b_own[4:0] == 5'd1, "R11 one edge after write unchanged", 128'(b_own[4:0]), 1);
    settle();
    chk(b_own[4:0] == 5'd15, "R11 two edges after write", 128'(b_own[4:0]), 15);
    @(negedge clk); sig_out[14] = ~sig_out[14];
    @(negedge clk); #1;
    chk(b_out[0] == sig_out[14], "R11 data after one edge", 128'(b_out[0]), 128'(sig_out[14]));

    // random mix
    for (int it = 0; it < 200; it++) begin
      sig_out = 24'($urandom); sig_oe = 24'($urandom);
      latch = 24'($urandom); pin_in = 24'($urandom);
      wr(0, 8'($urandom)); wr(1, 8'($urandom));
      wr(2, 8'(($urandom & 3) | (($urandom % 4 != 0) ? 8'h40 : 8'h00)));
      settle();
      cmp_both("rand", 1'b0);
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule